// File: doc/BRIEF.md
# BCD Calendar Counter

This block keeps the time of day and the calendar date in packed BCD bytes: seconds, minutes, hours, day of month, weekday, month and a two-digit year with a century flag. A prescaler counts the enable pulses of a slow reference (32.768 kHz by default) and produces one advance per second. That advance ripples through the fields in a single cycle. The day of month wraps at 28, 29, 30 or 31, depending on the month and the year.

Software reaches the block through a byte-wide register port: an address, write data, a write strobe and combinational read data. A control byte holds a halt bit and two scratch test bits. While the halt bit is set, counting is frozen so that a new time can be loaded. Any time write during the halt restarts the sub-second count, so the first second after resuming is a full one. A flag in the top bit of the seconds byte is set by reset and tells software that the time cannot be trusted until it has been written. Minutes, hours, day and weekday are also driven on dedicated outputs, together with a one-cycle seconds pulse, for neighbouring alarm and timer logic.

The run control is a two-state machine. In `ST_RUN` the prescaler counts. In `ST_HALT` the prescaler and all fields hold. A control write with bit 5 set takes the transition *halt-request* (ST_RUN to ST_HALT). A control write with bit 5 clear takes *resume* (ST_HALT to ST_RUN). Any other control write keeps the current state.

Top module: `rtc_calendar`

## Requirements
- R1: After reset, reads return: address 0x00 = 0x00, 0x02 = 0x80, 0x03 = 0x00, 0x04 = 0x00, 0x05 = 0x01, 0x06 = 0x00, 0x07 = 0x01, 0x08 = 0x00.
- R2: While running, the seconds byte advances once every PRESCALE_DIV cycles in which `ref_tick` is high, and cycles with `ref_tick` low do not count. `sec_pulse` is high for exactly the one cycle that follows each prescaler wrap.
- R3: Seconds (address 0x02, bits 6:0) wrap 59 to 00 and carry into minutes (0x03). Minutes wrap 59 to 00 and carry into hours (0x04). Hours wrap 23 to 00 and advance both the day and the weekday (0x06, which runs 0 to 6 and wraps 6 to 0).
- R4: The day (0x05) wraps to 01 after 31 in months 01, 03, 05, 07, 08, 10 and 12, after 30 in months 04, 06, 09 and 11, and after 28 in month 02. In month 02 it wraps after 29 instead when the BCD year is divisible by 4. The month (0x07, bits 4:0) then advances.
- R5: Month 12 wraps to 01 and advances the year (0x08). Year 99 wraps to 00 and toggles the century flag in bit 7 of address 0x07. A write to 0x07 loads that flag from write-data bit 7.
- R6: Address 0x00 bit 5 is the halt bit. While it reads 1, no field and no sub-second count changes except by a write. Bits 7 and 3 read back as last written. All other bits of 0x00 read 0.
- R7: A write to any of the addresses 0x02 to 0x08 while halted clears the prescaler. After resuming, the first advance needs a full PRESCALE_DIV counted cycles.
- R8: Bit 7 of address 0x02 is the invalid-time flag. Reset sets it. A write to 0x02 loads it from write-data bit 7, so a write with bit 7 at 0 clears it.
- R9: Writes are stored under these masks: seconds 0x7F, minutes 0x7F, hours 0x3F, day 0x3F, weekday 0x07, month 0x1F (plus the century flag at bit 7), year 0xFF. Masked bits read 0.
- R10: If a write to one of the addresses 0x02 to 0x08 lands in the same cycle as a prescaler wrap, the write is stored and no field advances in that cycle.
- R11: Reads of address 0x01 and of 0x09 to 0x0F return 0x00, and writes to them change nothing.
- R12: `cal_min`, `cal_hour`, `cal_mday` and `cal_wday` always equal the bytes read at addresses 0x03, 0x04, 0x05 and 0x06.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | One-cycle enable per reference period |
| reg_addr | input | ADDR_W | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| sec_pulse | output | 1 | One-cycle pulse after each second |
| cal_min | output | 8 | Minutes, BCD |
| cal_hour | output | 8 | Hours, BCD |
| cal_mday | output | 8 | Day of month, BCD |
| cal_wday | output | 8 | Weekday 0 to 6 |

## Verification
The range assertions on the fields take for granted that software writes only valid BCD values inside each field's range, and a day that exists in the loaded month. The stimulus obeys this: it uses only legal dates, and the masking tests pick raw bytes whose masked result is still a legal value. A behavioural model in the bench tracks the prescaler, the halt state and the calendar in integers. That model is also used to place a time write exactly on a prescaler wrap.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    typedef enum logic [0:0] {
        ST_RUN  = 1'b0,
        ST_HALT = 1'b1
    } run_state_t;

    localparam int unsigned NUM_FIELDS = 7;
    localparam int unsigned FIRST_TIME_ADDR = 2;
    localparam int unsigned CTRL_ADDR = 0;

    localparam int unsigned FLD_SEC  = 0;
    localparam int unsigned FLD_MIN  = 1;
    localparam int unsigned FLD_HOUR = 2;
    localparam int unsigned FLD_DAY  = 3;
    localparam int unsigned FLD_WDAY = 4;
    localparam int unsigned FLD_MON  = 5;
    localparam int unsigned FLD_YEAR = 6;

    localparam int unsigned CTRL_HALT_BIT = 5;
    localparam int unsigned FLAG_BIT = 7;

    localparam logic [7:0] FIELD_MASK [NUM_FIELDS] =
        '{8'h7F, 8'h7F, 8'h3F, 8'h3F, 8'h07, 8'h1F, 8'hFF};
    localparam logic [7:0] FIELD_RESET [NUM_FIELDS] =
        '{8'h00, 8'h00, 8'h00, 8'h01, 8'h00, 8'h01, 8'h00};

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        else
            return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic bcd_year_leap(input logic [7:0] y);
        logic [4:0] s;
        s = {y[7:4], 1'b0} + {1'b0, y[3:0]};
        return (s[1:0] == 2'b00);
    endfunction

    function automatic logic [7:0] bcd_month_last(input logic [7:0] mon,
                                                  input logic [7:0] yr);
        case (mon)
            8'h02:                      return bcd_year_leap(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int unsigned DIV = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic ref_tick,
    input  logic clear,
    output logic tick
);
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;
    logic          at_last;

    generate
        if ((DIV & (DIV - 1)) == 0) begin : g_pow2
            assign at_last = &cnt_q;
        end else begin : g_any
            assign at_last = (cnt_q == LAST);
        end
    endgenerate

    assign tick = run & ref_tick & at_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clear)
            cnt_q <= '0;
        else if (run && ref_tick)
            cnt_q <= at_last ? '0 : cnt_q + 1'b1;
    end

    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ref_tick && !clear) |=> $stable(cnt_q));

    p_halt_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clear) |=> $stable(cnt_q));

    p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt_q == '0));

endmodule

// File: rtl/rtc_run_ctrl.sv
module rtc_run_ctrl
    import rtc_cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_wr,
    input  logic [7:0] ctrl_wdata,
    output logic       run,
    output logic [7:0] ctrl_rd
);
    run_state_t state_q, state_d;
    logic       test_hi_q, test_lo_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_RUN;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (ctrl_wr && ctrl_wdata[CTRL_HALT_BIT])  state_d = ST_HALT;
            ST_HALT: if (ctrl_wr && !ctrl_wdata[CTRL_HALT_BIT]) state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            test_hi_q <= 1'b0;
            test_lo_q <= 1'b0;
        end else if (ctrl_wr) begin
            test_hi_q <= ctrl_wdata[7];
            test_lo_q <= ctrl_wdata[3];
        end
    end

    always_comb begin
        run     = (state_q == ST_RUN);
        ctrl_rd = {test_hi_q, 1'b0, ~run, 1'b0, test_lo_q, 3'b000};
    end

    p_halt_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && ctrl_wdata[CTRL_HALT_BIT]) |=> !run);

    p_resume_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !ctrl_wdata[CTRL_HALT_BIT]) |=> run);

    p_state_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> $stable(run));

endmodule

// File: rtl/rtc_time_regs.sv
module rtc_time_regs
    import rtc_cal_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  adv,
    input  logic [NUM_FIELDS-1:0] wr_sel,
    input  logic [7:0]            wdata,
    output logic [7:0]            sec_o,
    output logic [7:0]            min_o,
    output logic [7:0]            hour_o,
    output logic [7:0]            day_o,
    output logic [7:0]            wday_o,
    output logic [7:0]            mon_o,
    output logic [7:0]            year_o,
    output logic                  flag_o,
    output logic                  cent_o
);
    logic [7:0] fld_q  [NUM_FIELDS];
    logic [7:0] fld_nx [NUM_FIELDS];
    logic       flag_q, cent_q, cent_nx;
    logic       c_min, c_hour, c_day, c_mon, c_year;
    logic [7:0] day_last;

    always_comb begin
        day_last = bcd_month_last(fld_q[FLD_MON], fld_q[FLD_YEAR]);
        c_min  = (fld_q[FLD_SEC] == 8'h59);
        c_hour = c_min  && (fld_q[FLD_MIN] == 8'h59);
        c_day  = c_hour && (fld_q[FLD_HOUR] == 8'h23);
        c_mon  = c_day  && (fld_q[FLD_DAY] == day_last);
        c_year = c_mon  && (fld_q[FLD_MON] == 8'h12);

        fld_nx[FLD_SEC]  = c_min ? 8'h00 : bcd_inc(fld_q[FLD_SEC]);
        fld_nx[FLD_MIN]  = !c_min  ? fld_q[FLD_MIN] :
                           (c_hour ? 8'h00 : bcd_inc(fld_q[FLD_MIN]));
        fld_nx[FLD_HOUR] = !c_hour ? fld_q[FLD_HOUR] :
                           (c_day ? 8'h00 : bcd_inc(fld_q[FLD_HOUR]));
        fld_nx[FLD_WDAY] = !c_day ? fld_q[FLD_WDAY] :
                           ((fld_q[FLD_WDAY] == 8'h06) ? 8'h00 : fld_q[FLD_WDAY] + 8'h01);
        fld_nx[FLD_DAY]  = !c_day ? fld_q[FLD_DAY] :
                           (c_mon ? 8'h01 : bcd_inc(fld_q[FLD_DAY]));
        fld_nx[FLD_MON]  = !c_mon ? fld_q[FLD_MON] :
                           (c_year ? 8'h01 : bcd_inc(fld_q[FLD_MON]));
        fld_nx[FLD_YEAR] = !c_year ? fld_q[FLD_YEAR] :
                           ((fld_q[FLD_YEAR] == 8'h99) ? 8'h00 : bcd_inc(fld_q[FLD_YEAR]));
        cent_nx = cent_q ^ (c_year && (fld_q[FLD_YEAR] == 8'h99));
    end

    genvar gi;
    generate
        for (gi = 0; gi < NUM_FIELDS; gi++) begin : g_field
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    fld_q[gi] <= FIELD_RESET[gi];
                else if (wr_sel[gi])
                    fld_q[gi] <= wdata & FIELD_MASK[gi];
                else if (adv)
                    fld_q[gi] <= fld_nx[gi];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b1;
            cent_q <= 1'b0;
        end else begin
            if (wr_sel[FLD_SEC])
                flag_q <= wdata[FLAG_BIT];
            if (wr_sel[FLD_MON])
                cent_q <= wdata[FLAG_BIT];
            else if (adv)
                cent_q <= cent_nx;
        end
    end

    assign sec_o  = fld_q[FLD_SEC];
    assign min_o  = fld_q[FLD_MIN];
    assign hour_o = fld_q[FLD_HOUR];
    assign day_o  = fld_q[FLD_DAY];
    assign wday_o = fld_q[FLD_WDAY];
    assign mon_o  = fld_q[FLD_MON];
    assign year_o = fld_q[FLD_YEAR];
    assign flag_o = flag_q;
    assign cent_o = cent_q;

    p_sec_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fld_q[FLD_SEC] <= 8'h59) && (fld_q[FLD_SEC][3:0] <= 4'd9));

    p_hour_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fld_q[FLD_HOUR] <= 8'h23);

    p_wday_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fld_q[FLD_WDAY] <= 8'h06);

    p_day_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fld_q[FLD_DAY] >= 8'h01) && (fld_q[FLD_DAY] <= 8'h31));

    p_month_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fld_q[FLD_MON] >= 8'h01) && (fld_q[FLD_MON] <= 8'h12));

    p_century_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !wr_sel[FLD_MON] && fld_q[FLD_YEAR] == 8'h99 && fld_q[FLD_MON] == 8'h12 &&
         fld_q[FLD_DAY] == 8'h31 && fld_q[FLD_HOUR] == 8'h23 &&
         fld_q[FLD_MIN] == 8'h59 && fld_q[FLD_SEC] == 8'h59)
        |=> (cent_q != $past(cent_q)));

    p_flag_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_q) |-> $past(wr_sel[FLD_SEC] && !wdata[FLAG_BIT]));

    p_flag_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(wr_sel[FLD_SEC] && wdata[FLAG_BIT]));

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_cal_pkg::*;
#(
    parameter int unsigned PRESCALE_DIV = 32768,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              sec_pulse,
    output logic [7:0]        cal_min,
    output logic [7:0]        cal_hour,
    output logic [7:0]        cal_mday,
    output logic [7:0]        cal_wday
);
    logic [NUM_FIELDS-1:0] wr_sel;
    logic       ctrl_wr, time_wr, run, tick, adv, pre_clear;
    logic [7:0] ctrl_rd;
    logic [7:0] sec_v, min_v, hour_v, day_v, wday_v, mon_v, year_v;
    logic       flag_v, cent_v;
    logic       pulse_q;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_FIELDS; gi++) begin : g_dec
            assign wr_sel[gi] = reg_wr && (reg_addr == ADDR_W'(FIRST_TIME_ADDR + gi));
        end
    endgenerate

    assign ctrl_wr   = reg_wr && (reg_addr == ADDR_W'(CTRL_ADDR));
    assign time_wr   = |wr_sel;
    assign adv       = tick && !time_wr;
    assign pre_clear = !run && time_wr;

    rtc_run_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .ctrl_wdata (reg_wdata),
        .run        (run),
        .ctrl_rd    (ctrl_rd)
    );

    rtc_prescaler #(.DIV(PRESCALE_DIV)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .ref_tick (ref_tick),
        .clear    (pre_clear),
        .tick     (tick)
    );

    rtc_time_regs u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (adv),
        .wr_sel (wr_sel),
        .wdata  (reg_wdata),
        .sec_o  (sec_v),
        .min_o  (min_v),
        .hour_o (hour_v),
        .day_o  (day_v),
        .wday_o (wday_v),
        .mon_o  (mon_v),
        .year_o (year_v),
        .flag_o (flag_v),
        .cent_o (cent_v)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pulse_q <= 1'b0;
        else
            pulse_q <= tick;
    end

    always_comb begin
        case (reg_addr)
            ADDR_W'(0): reg_rdata = ctrl_rd;
            ADDR_W'(2): reg_rdata = {flag_v, sec_v[6:0]};
            ADDR_W'(3): reg_rdata = min_v;
            ADDR_W'(4): reg_rdata = hour_v;
            ADDR_W'(5): reg_rdata = day_v;
            ADDR_W'(6): reg_rdata = wday_v;
            ADDR_W'(7): reg_rdata = {cent_v, mon_v[6:0]};
            ADDR_W'(8): reg_rdata = year_v;
            default:    reg_rdata = 8'h00;
        endcase
    end

    assign sec_pulse = pulse_q;
    assign cal_min   = min_v;
    assign cal_hour  = hour_v;
    assign cal_mday  = day_v;
    assign cal_wday  = wday_v;

    p_tick_needs_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> run);

    p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> (sec_v != $past(sec_v)));

    p_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && wr_sel[FLD_MIN]) |=> (sec_v == $past(sec_v)));

    p_pulse_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (PRESCALE_DIV > 1 && sec_pulse) |=> !sec_pulse);

endmodule

// File: tb/rtc_calendar_tb.sv
module rtc_calendar_tb;
    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_tick = 1'b0;
    logic [3:0] reg_addr = 4'h0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       sec_pulse;
    logic [7:0] cal_min, cal_hour, cal_mday, cal_wday;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    rtc_calendar #(.PRESCALE_DIV(DIV), .ADDR_W(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sec_pulse(sec_pulse), .cal_min(cal_min), .cal_hour(cal_hour),
        .cal_mday(cal_mday), .cal_wday(cal_wday)
    );

    // behavioural model
    logic [7:0] m_sec, m_min, m_hr, m_day, m_wd, m_mon, m_yr;
    bit m_cen, m_vl, m_stop, m_t7, m_t3, m_pulse;
    int m_pc;

    function automatic int b2i(logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic logic [7:0] i2b(int v);
        return 8'(((v / 10) * 16) + (v % 10));
    endfunction

    function automatic int mdays(int mo, int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic m_reset();
        m_sec = 0; m_min = 0; m_hr = 0; m_day = 8'h01; m_wd = 0;
        m_mon = 8'h01; m_yr = 0; m_cen = 0; m_vl = 1; m_stop = 0;
        m_t7 = 0; m_t3 = 0; m_pulse = 0; m_pc = 0;
    endtask

    task automatic m_advance();
        int v;
        v = b2i(m_sec) + 1;
        if (v < 60) begin m_sec = i2b(v); return; end
        m_sec = 0;
        v = b2i(m_min) + 1;
        if (v < 60) begin m_min = i2b(v); return; end
        m_min = 0;
        v = b2i(m_hr) + 1;
        if (v < 24) begin m_hr = i2b(v); return; end
        m_hr = 0;
        m_wd = i2b((b2i(m_wd) + 1) % 7);
        v = b2i(m_day) + 1;
        if (v <= mdays(b2i(m_mon), b2i(m_yr))) begin m_day = i2b(v); return; end
        m_day = 8'h01;
        v = b2i(m_mon) + 1;
        if (v <= 12) begin m_mon = i2b(v); return; end
        m_mon = 8'h01;
        v = b2i(m_yr) + 1;
        if (v < 100) m_yr = i2b(v);
        else begin m_yr = 0; m_cen = !m_cen; end
    endtask

    function automatic logic [7:0] m_read(logic [3:0] a);
        case (a)
            4'h0: return {m_t7, 1'b0, m_stop, 1'b0, m_t3, 3'b000};
            4'h2: return {m_vl, m_sec[6:0]};
            4'h3: return m_min;
            4'h4: return m_hr;
            4'h5: return m_day;
            4'h6: return m_wd;
            4'h7: return {m_cen, m_mon[6:0]};
            4'h8: return m_yr;
            default: return 8'h00;
        endcase
    endfunction

    task automatic m_update(bit we, logic [3:0] a, logic [7:0] d, bit rt);
        bit tw, tk;
        tw = we && a >= 4'h2 && a <= 4'h8;
        tk = !m_stop && rt && (m_pc == DIV - 1);
        if (m_stop) begin
            if (tw) m_pc = 0;
        end else if (rt) begin
            m_pc = (m_pc == DIV - 1) ? 0 : m_pc + 1;
        end
        m_pulse = tk;
        if (tk && !tw) m_advance();
        if (we) begin
            case (a)
                4'h0: begin m_stop = d[5]; m_t7 = d[7]; m_t3 = d[3]; end
                4'h2: begin m_sec = d & 8'h7F; m_vl = d[7]; end
                4'h3: m_min = d & 8'h7F;
                4'h4: m_hr = d & 8'h3F;
                4'h5: m_day = d & 8'h3F;
                4'h6: m_wd = d & 8'h07;
                4'h7: begin m_mon = d & 8'h1F; m_cen = d[7]; end
                4'h8: m_yr = d;
                default: ;
            endcase
        end
    endtask

    task automatic compare(string tag);
        logic [8:0] exp_a, act_a;
        logic [31:0] exp_b, act_b;
        exp_a = {m_pulse, m_read(reg_addr)};
        act_a = {sec_pulse, reg_rdata};
        checks++;
        if (act_a !== exp_a) begin
            errors++;
            $display("FAIL %s addr=%0h pulse/rdata actual=%h expected=%h", tag, reg_addr, act_a, exp_a);
        end
        exp_b = {m_min, m_hr, m_day, m_wd};
        act_b = {cal_min, cal_hour, cal_mday, cal_wday};
        checks++;
        if (act_b !== exp_b) begin
            errors++;
            $display("FAIL R12 cal outputs actual=%h expected=%h", act_b, exp_b);
        end
    endtask

    task automatic step(bit we, logic [3:0] a, logic [7:0] d, bit rt, string tag);
        reg_wr = we; reg_addr = a; reg_wdata = d; ref_tick = rt;
        m_update(we, a, d, rt);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic peek(logic [3:0] a, logic [7:0] exp, string tag);
        reg_addr = a;
        #1;
        checks++;
        if (reg_rdata !== exp) begin
            errors++;
            $display("FAIL %s peek addr=%0h actual=%h expected=%h", tag, a, reg_rdata, exp);
        end
    endtask

    task automatic run_steps(int n, bit alt, string tag);
        for (int i = 0; i < n; i++)
            step(1'b0, 4'(i % 16), 8'h00, alt ? bit'(i % 2) : 1'b1, tag);
    endtask

    task automatic set_time(logic [7:0] s, logic [7:0] mi, logic [7:0] h, logic [7:0] dy,
                            logic [7:0] w, logic [7:0] mo, logic [7:0] y);
        step(1'b1, 4'h0, 8'h20, 1'b0, "R6");
        step(1'b1, 4'h2, s,  1'b1, "R7");
        step(1'b1, 4'h3, mi, 1'b1, "R7");
        step(1'b1, 4'h4, h,  1'b1, "R7");
        step(1'b1, 4'h5, dy, 1'b1, "R7");
        step(1'b1, 4'h6, w,  1'b1, "R7");
        step(1'b1, 4'h7, mo, 1'b1, "R7");
        step(1'b1, 4'h8, y,  1'b1, "R7");
        step(1'b1, 4'h0, 8'h00, 1'b0, "R6");
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        logic [7:0] held;
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1, R8: reset values
        peek(4'h0, 8'h00, "R1");
        peek(4'h2, 8'h80, "R8");
        peek(4'h5, 8'h01, "R1");
        peek(4'h7, 8'h01, "R1");
        peek(4'h8, 8'h00, "R1");
        // R2: steady and gapped reference
        run_steps(40, 1'b0, "R2");
        run_steps(40, 1'b1, "R2");
        // R3/R4: non-leap February end, seconds to month carry
        run_steps(2, 1'b0, "R7");
        set_time(8'h58, 8'h59, 8'h23, 8'h28, 8'h06, 8'h02, 8'h23);
        peek(4'h2, 8'h58, "R8");
        peek(4'h0, 8'h00, "R6");
        // R7: first second after resume is a full interval
        run_steps(DIV - 1, 1'b0, "R7");
        peek(4'h2, 8'h58, "R7");
        run_steps(1, 1'b0, "R7");
        peek(4'h2, 8'h59, "R7");
        run_steps(DIV, 1'b0, "R3");
        peek(4'h2, 8'h00, "R3");
        peek(4'h3, 8'h00, "R3");
        peek(4'h4, 8'h00, "R3");
        peek(4'h6, 8'h00, "R3");
        peek(4'h5, 8'h01, "R4");
        peek(4'h7, 8'h03, "R4");
        // R6: halt freezes, test bits read back
        step(1'b1, 4'h0, 8'hA8, 1'b1, "R6");
        peek(4'h0, 8'hA8, "R6");
        held = 8'h00;
        run_steps(12, 1'b0, "R6");
        peek(4'h2, 8'h00, "R6");
        step(1'b1, 4'h0, 8'h00, 1'b0, "R6");
        peek(4'h0, 8'h00, "R6");
        // R4: leap February
        set_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h03, 8'h02, 8'h24);
        run_steps(DIV, 1'b0, "R4");
        peek(4'h5, 8'h29, "R4");
        peek(4'h7, 8'h02, "R4");
        set_time(8'h59, 8'h59, 8'h23, 8'h29, 8'h03, 8'h02, 8'h24);
        run_steps(DIV, 1'b0, "R4");
        peek(4'h5, 8'h01, "R4");
        peek(4'h7, 8'h03, "R4");
        set_time(8'h59, 8'h59, 8'h23, 8'h30, 8'h02, 8'h04, 8'h31);
        run_steps(DIV, 1'b0, "R4");
        peek(4'h5, 8'h01, "R4");
        peek(4'h7, 8'h05, "R4");
        set_time(8'h59, 8'h59, 8'h23, 8'h30, 8'h02, 8'h01, 8'h31);
        run_steps(DIV, 1'b0, "R4");
        peek(4'h5, 8'h31, "R4");
        peek(4'h7, 8'h01, "R4");
        // R5: year and century
        set_time(8'h59, 8'h59, 8'h23, 8'h31, 8'h06, 8'h12, 8'h99);
        run_steps(DIV, 1'b0, "R5");
        peek(4'h8, 8'h00, "R5");
        peek(4'h7, 8'h81, "R5");
        peek(4'h6, 8'h00, "R5");
        set_time(8'h59, 8'h59, 8'h23, 8'h31, 8'h01, 8'h92, 8'h99);
        run_steps(DIV, 1'b0, "R5");
        peek(4'h7, 8'h01, "R5");
        set_time(8'h59, 8'h59, 8'h23, 8'h31, 8'h01, 8'h12, 8'h41);
        run_steps(DIV, 1'b0, "R5");
        peek(4'h8, 8'h42, "R5");
        peek(4'h7, 8'h01, "R5");
        // R9: masks, R8: flag load
        step(1'b1, 4'h0, 8'hFF, 1'b0, "R9");
        peek(4'h0, 8'hA8, "R9");
        step(1'b1, 4'h3, 8'hA5, 1'b1, "R9"); peek(4'h3, 8'h25, "R9");
        step(1'b1, 4'h4, 8'hD2, 1'b1, "R9"); peek(4'h4, 8'h12, "R9");
        step(1'b1, 4'h5, 8'hC5, 1'b1, "R9"); peek(4'h5, 8'h05, "R9");
        step(1'b1, 4'h6, 8'hFE, 1'b1, "R9"); peek(4'h6, 8'h06, "R9");
        step(1'b1, 4'h7, 8'h71, 1'b1, "R9"); peek(4'h7, 8'h11, "R9");
        step(1'b1, 4'h2, 8'h85, 1'b1, "R8"); peek(4'h2, 8'h85, "R8");
        step(1'b1, 4'h2, 8'h05, 1'b1, "R8"); peek(4'h2, 8'h05, "R8");
        // R11: unused addresses
        step(1'b1, 4'h1, 8'h5A, 1'b1, "R11"); peek(4'h1, 8'h00, "R11");
        step(1'b1, 4'hA, 8'hFF, 1'b1, "R11"); peek(4'hA, 8'h00, "R11");
        peek(4'hF, 8'h00, "R11");
        peek(4'h2, 8'h05, "R11");
        peek(4'h3, 8'h25, "R11");
        step(1'b1, 4'h0, 8'h00, 1'b0, "R6");
        // R10: write lands on a wrap
        run_steps(5, 1'b0, "R10");
        while (m_pc != DIV - 1) step(1'b0, 4'h2, 8'h00, 1'b1, "R10");
        peek(4'h2, m_read(4'h2), "R10");
        held = reg_rdata;
        step(1'b1, 4'h3, 8'h17, 1'b1, "R10");
        peek(4'h2, held, "R10");
        peek(4'h3, 8'h17, "R10");
        checks++;
        if (sec_pulse !== 1'b1) begin
            errors++;
            $display("FAIL R2 pulse on suppressed wrap actual=%b expected=1", sec_pulse);
        end
        run_steps(60, 1'b0, "R2");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule